// File: doc/BRIEF.md
# Register-Level Serial Port Controller

This block is a serial slave that gives a host access to a small bank of configuration registers of different widths. Each transaction has two phases. In the first, eight serial-clock rising edges shift in an instruction byte that says whether the access is a read or a write and which register it targets. In the second, the controller moves exactly as many data bytes as that register holds. It walks through the register's byte lanes by itself, so the host never supplies byte addresses.

The serial inputs are sampled with a fast system clock. Rising serial-clock edges capture incoming data, and falling edges advance read data on the output. Each register's contents are presented in parallel on a flat bus, one 32-bit slot per register, with unused upper bits held at zero. An abort input, or releasing chip select, ends any transfer early: bytes that were partly shifted in are discarded, and the controller waits for a fresh instruction. Bit 1 of the 3-byte register at address 1 is also brought out on its own pin as an enable for a reference-clock output.

Top module: `regser_port`

## Requirements
- R1: The first eight rising serial-clock edges of a transaction carry the instruction byte, most significant bit first. Bit 7 set means read and bit 7 clear means write. Bits 4:0 give the register address. Bits 6:5 have no effect.
- R2: The data phase is as long as the addressed register is wide: address 0 takes 4 bytes, 1 takes 3, 2 takes 2, 3 takes 1, 4 takes 4 and 5 takes 2.
- R3: Write data arrives most significant bit first across the whole register. The register and its parallel slot keep their old value until the final data byte has arrived, and then take the new value.
- R4: Read data is driven on `sdo`, which changes only on falling serial-clock edges. The most significant bit of the register appears after the falling edge that follows the eighth instruction rising edge.
- R5: After the final data byte, the next eight rising edges are taken as a new instruction without any toggle of chip select.
- R6: Asserting `resync` discards a partly shifted write and returns the controller to the instruction phase, and a new instruction may follow at once without leaving the transaction.
- R7: Raising `cs_n` in the middle of a transfer discards it in the same way, and the registers keep their old values.
- R8: Addresses 6 to 31 get a 1-byte data phase. A write to one of them changes no register, and a read from one returns zero.
- R9: `refout_en` equals bit 1 of the register at address 1.
- R10: After reset, every register slot reads zero, `sdo` is low and the controller expects an instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in, captured on sclk rising edges |
| cs_n | input | 1 | Active-low chip select |
| resync | input | 1 | Active-high abort that returns the port to the instruction phase |
| sdo | output | 1 | Serial read data, updated on sclk falling edges |
| reg_flat | output | 192 | Register contents, one 32-bit slot per address; slot i occupies bits 32*i+31:32*i |
| refout_en | output | 1 | Reference-clock output enable, bit 1 of register 1 |

## Verification
The assertions assume that each serial-clock level lasts several system-clock cycles. They also assume that `sdi` is stable around each sampled rising edge, so that the synchronised clock and data stay aligned and no rising and falling events arrive back to back. The bench holds each serial-clock half period for eight system-clock cycles, changes `sdi` only while the serial clock is low, and asserts `resync` or raises `cs_n` only while the serial clock is low. Read data is sampled just before each rising edge, well after the falling edge has moved `sdo`.

// File: rtl/regser_pkg.sv
// Package regser_pkg: shared constants, register width table and phase type
// for the register-level serial port. Assumes at most 32 registers and
// registers no wider than one 32-bit slot.
package regser_pkg;
    localparam int SLOT_W    = 32;
    localparam int ADDR_W    = 5;
    localparam int NUM_REGS  = 6;
    localparam int MAX_BYTES = SLOT_W / 8;
    localparam int BCNT_W    = $clog2(MAX_BYTES);
    localparam int SH_W      = $clog2(SLOT_W) + 1;

    typedef enum logic {
        PH_INSTR = 1'b0,
        PH_DATA  = 1'b1
    } phase_e;

    // Byte count of the register at address a; undefined addresses take one byte.
    function automatic int unsigned reg_bytes(input logic [ADDR_W-1:0] a);
        case (a)
            5'd0:    return 4;
            5'd1:    return 3;
            5'd2:    return 2;
            5'd3:    return 1;
            5'd4:    return 4;
            5'd5:    return 2;
            default: return 1;
        endcase
    endfunction

    // True when address a names a register that exists.
    function automatic logic reg_defined(input logic [ADDR_W-1:0] a);
        return (int'(a) < NUM_REGS);
    endfunction
endpackage

// File: rtl/regser_sync.sv
// Module regser_sync: brings the four serial-side inputs into the clk domain
// through STAGES flops and derives single-cycle rising and falling events of
// the serial clock. Assumes each serial-clock level lasts several clk cycles.
module regser_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic sdi,
    input  logic cs_n,
    input  logic resync,
    output logic sdi_s,
    output logic rise_evt,
    output logic fall_evt,
    output logic hold
);
    localparam int         NSIG    = 4;
    localparam logic [3:0] RST_VAL = 4'b0100;  // {resync, cs_n, sdi, sclk}

    logic [NSIG-1:0] stage_q [STAGES];
    logic            sclk_d;

    // First synchroniser stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= {resync, cs_n, sdi, sclk};
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            // Further stages shift the sampled vector along.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    endgenerate

    // Delayed copy of the synchronised serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= stage_q[STAGES-1][0];
    end

    assign sdi_s    = stage_q[STAGES-1][1];
    assign hold     = stage_q[STAGES-1][3] | stage_q[STAGES-1][2];
    assign rise_evt = stage_q[STAGES-1][0] & ~sclk_d;
    assign fall_evt = ~stage_q[STAGES-1][0] & sclk_d;
endmodule

// File: rtl/regser_seq.sv
// Module regser_seq: instruction/data phase sequencer. It counts bits and
// bytes, decodes the instruction, looks up the data-phase length, assembles
// write data and shifts read data out. Assumes rise and fall events are
// never in the same cycle and that hold overrides both.
module regser_seq
    import regser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              sdi_s,
    input  logic              hold,
    input  logic [SLOT_W-1:0] rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              sdo,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [SLOT_W-1:0] wr_data
);
    phase_e              phase;
    logic [2:0]          bit_cnt;
    logic [BCNT_W-1:0]   byte_cnt;
    logic [BCNT_W-1:0]   last_byte;
    logic                is_read;
    logic [ADDR_W-1:0]   addr;
    logic [6:0]          ishift;
    logic [SLOT_W-2:0]   acc;
    logic [SLOT_W-1:0]   rd_shift;
    logic [7:0]          instr_next;
    logic [BCNT_W-1:0]   nb_new;
    logic [SH_W-1:0]     rd_sh;
    logic [SLOT_W-1:0]   rd_aligned;

    // Decode the instruction as it completes and left-align the read word.
    always_comb begin
        instr_next = {ishift, sdi_s};
        rd_addr    = instr_next[ADDR_W-1:0];
        nb_new     = BCNT_W'(reg_bytes(rd_addr) - 1);
        rd_sh      = SH_W'(8 * (MAX_BYTES - int'(reg_bytes(rd_addr))));
        rd_aligned = rd_word << rd_sh;
    end

    // Phase sequencing, shifting, write commit and read data output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_INSTR;
            bit_cnt   <= '0;
            byte_cnt  <= '0;
            last_byte <= '0;
            is_read   <= 1'b0;
            addr      <= '0;
            ishift    <= '0;
            acc       <= '0;
            rd_shift  <= '0;
            sdo       <= 1'b0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (hold) begin
                phase    <= PH_INSTR;
                bit_cnt  <= '0;
                byte_cnt <= '0;
                ishift   <= '0;
                acc      <= '0;
                sdo      <= 1'b0;
            end else if (rise_evt) begin
                bit_cnt <= bit_cnt + 3'd1;
                if (phase == PH_INSTR) begin
                    ishift <= instr_next[6:0];
                    if (bit_cnt == 3'd7) begin
                        phase     <= PH_DATA;
                        is_read   <= instr_next[7];
                        addr      <= rd_addr;
                        last_byte <= nb_new;
                        byte_cnt  <= '0;
                        acc       <= '0;
                        rd_shift  <= rd_aligned;
                    end
                end else begin
                    acc <= {acc[SLOT_W-3:0], sdi_s};
                    if (bit_cnt == 3'd7) begin
                        if (byte_cnt == last_byte) begin
                            phase    <= PH_INSTR;
                            byte_cnt <= '0;
                            ishift   <= '0;
                            if (!is_read && reg_defined(addr)) begin
                                wr_en   <= 1'b1;
                                wr_addr <= addr;
                                wr_data <= {acc, sdi_s};
                            end
                        end else begin
                            byte_cnt <= byte_cnt + 1'b1;
                        end
                    end
                end
            end else if (fall_evt) begin
                if (phase == PH_DATA && is_read) begin
                    sdo      <= rd_shift[SLOT_W-1];
                    rd_shift <= rd_shift << 1;
                end else begin
                    sdo <= 1'b0;
                end
            end
        end
    end

    // R1
    instr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_INSTR && rise_evt && !hold && bit_cnt == 3'd7) |=> (phase == PH_DATA));

    // R2
    data_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA) |-> (byte_cnt <= last_byte));

    // R5
    next_instr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && rise_evt && !hold && bit_cnt == 3'd7 && byte_cnt == last_byte)
        |=> (phase == PH_INSTR && bit_cnt == 3'd0));

    // R6
    hold_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (phase == PH_INSTR && bit_cnt == 3'd0 && byte_cnt == '0 && !wr_en));

    // R4
    sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall_evt && !hold) |=> $stable(sdo));

    // R8
    wr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < NUM_REGS));
endmodule

// File: rtl/regser_regbank.sv
// Module regser_regbank: holds the configuration registers, each masked to
// its own byte width, with a whole-register write port and a read mux that
// returns zero for undefined addresses. Assumes wr_en is a one-cycle pulse.
module regser_regbank
    import regser_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [SLOT_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [SLOT_W-1:0]          rd_word,
    output logic [NUM_REGS*SLOT_W-1:0] reg_flat
);
    logic [SLOT_W-1:0] regs [NUM_REGS];

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            localparam int          W    = 8 * int'(reg_bytes(ADDR_W'(g)));
            localparam logic [SLOT_W-1:0] MASK = (W >= SLOT_W) ? '1 :
                                                 ((SLOT_W'(1) << W) - SLOT_W'(1));

            // Register g takes the masked write word when addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)                                 regs[g] <= '0;
                else if (wr_en && wr_addr == ADDR_W'(g))    regs[g] <= wr_data & MASK;
            end

            assign reg_flat[g*SLOT_W +: SLOT_W] = regs[g];

            // R3
            reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_en && wr_addr == ADDR_W'(g)) |=> $stable(regs[g]));
        end
    endgenerate

    // Read mux over the defined registers; others read zero.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADDR_W'(i)) rd_word = regs[i];
        end
    end
endmodule

// File: rtl/regser_port.sv
// Module regser_port: top of the register-level serial port. Synchronises
// the serial pins, runs the two-phase sequencer and holds the register bank,
// exposing all registers in parallel. Assumes sclk is much slower than clk.
module regser_port
    import regser_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sclk,
    input  logic                       sdi,
    input  logic                       cs_n,
    input  logic                       resync,
    output logic                       sdo,
    output logic [NUM_REGS*SLOT_W-1:0] reg_flat,
    output logic                       refout_en
);
    localparam int REFOUT_BIT = SLOT_W * 1 + 1;

    logic              sdi_s;
    logic              rise_evt;
    logic              fall_evt;
    logic              hold;
    logic [SLOT_W-1:0] rd_word;
    logic [ADDR_W-1:0] rd_addr;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [SLOT_W-1:0] wr_data;

    regser_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk),
        .sdi      (sdi),
        .cs_n     (cs_n),
        .resync   (resync),
        .sdi_s    (sdi_s),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .hold     (hold)
    );

    regser_seq seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .sdi_s    (sdi_s),
        .hold     (hold),
        .rd_word  (rd_word),
        .rd_addr  (rd_addr),
        .sdo      (sdo),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    regser_regbank bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_word  (rd_word),
        .reg_flat (reg_flat)
    );

    assign refout_en = reg_flat[REFOUT_BIT];
endmodule

// File: tb/regser_port_tb_top.sv
module regser_port_tb_top;
    localparam int HP = 8;
    localparam int NR = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1, resync = 1'b0;
    logic sdo, refout_en;
    logic [NR*32-1:0] reg_flat;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    regser_port dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
        .resync(resync), .sdo(sdo), .reg_flat(reg_flat), .refout_en(refout_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] slot(input int i);
        return reg_flat[i*32 +: 32];
    endfunction

    task automatic bit_x(input logic b, output logic rb);
        @(negedge clk); sdi = b;
        repeat (HP-1) @(negedge clk);
        rb = sdo; sclk = 1'b1;
        repeat (HP) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic byte_x(input logic [7:0] b, output logic [7:0] rb);
        for (int i = 7; i >= 0; i--) begin
            logic r;
            bit_x(b[i], r);
            rb[i] = r;
        end
    endtask

    task automatic xfer(input logic [7:0] instr, input int nb, input logic [31:0] wd,
                        output logic [31:0] rd);
        logic [7:0] tmp;
        byte_x(instr, tmp);
        rd = '0;
        for (int k = nb-1; k >= 0; k--) begin
            byte_x(wd[k*8 +: 8], tmp);
            rd = {rd[23:0], tmp};
        end
        repeat (HP) @(negedge clk);
    endtask

    task automatic cs_on();  @(negedge clk); cs_n = 1'b0; repeat (HP) @(negedge clk); endtask
    task automatic cs_off(); repeat (HP) @(negedge clk); cs_n = 1'b1; repeat (HP) @(negedge clk); endtask

    task automatic t_reset();
        for (int i = 0; i < NR; i++) chk("R10 slot", slot(i), 32'h0);
        chk("R10 sdo", {31'b0, sdo}, 32'h0);
        chk("R10 refout_en", {31'b0, refout_en}, 32'h0);
    endtask

    task automatic t_ctrl2();
        logic [31:0] r;
        cs_on(); xfer(8'h01, 3, 32'hABCDEF, r); cs_off();
        chk("R2 3-byte slot1", slot(1), 32'h00ABCDEF);
        chk("R9 refout_en set", {31'b0, refout_en}, 32'h1);
        cs_on(); xfer(8'h01, 3, 32'hABCDED, r); cs_off();
        chk("R9 refout_en clear", {31'b0, refout_en}, 32'h0);
    endtask

    task automatic t_ftw_partial();
        logic [7:0] tmp;
        cs_on();
        byte_x(8'h04, tmp); byte_x(8'h12, tmp); byte_x(8'h34, tmp); byte_x(8'h56, tmp);
        repeat (HP) @(negedge clk);
        chk("R3 no commit before last byte", slot(4), 32'h0);
        byte_x(8'h78, tmp);
        repeat (HP) @(negedge clk);
        chk("R3 commit after last byte", slot(4), 32'h12345678);
        cs_off();
    endtask

    task automatic t_reads();
        logic [31:0] r;
        cs_on(); xfer(8'h84, 4, 32'h0, r); cs_off();
        chk("R4 read 4-byte msb first", r, 32'h12345678);
        cs_on(); xfer(8'h02, 2, 32'hBEEF, r); xfer(8'h82, 2, 32'h0, r); cs_off();
        chk("R2 2-byte slot2", slot(2), 32'h0000BEEF);
        chk("R4 read 2-byte", r, 32'h0000BEEF);
    endtask

    task automatic t_back2back();
        logic [31:0] r;
        cs_on();
        xfer(8'h03, 1, 32'h5A, r);
        xfer(8'h00, 4, 32'h11223344, r);
        xfer(8'h83, 1, 32'h0, r);
        cs_off();
        chk("R5 chained write slot3", slot(3), 32'h5A);
        chk("R5 chained write slot0", slot(0), 32'h11223344);
        chk("R5 chained read", r, 32'h5A);
    endtask

    task automatic t_abort();
        logic [7:0] tmp;
        logic [31:0] r;
        cs_on();
        byte_x(8'h00, tmp); byte_x(8'hDE, tmp); byte_x(8'hAD, tmp);
        @(negedge clk); resync = 1'b1; repeat (4) @(negedge clk); resync = 1'b0;
        repeat (HP) @(negedge clk);
        xfer(8'h05, 2, 32'h7E57, r);
        cs_off();
        chk("R6 aborted write discarded", slot(0), 32'h11223344);
        chk("R6 instruction after abort", slot(5), 32'h7E57);
    endtask

    task automatic t_cs_abort();
        logic [7:0] tmp;
        logic [31:0] r;
        cs_on(); byte_x(8'h05, tmp); byte_x(8'h99, tmp); cs_off();
        chk("R7 cs release discards", slot(5), 32'h7E57);
        cs_on(); xfer(8'h85, 2, 32'h0, r); cs_off();
        chk("R7 fresh instruction", r, 32'h7E57);
    endtask

    task automatic t_undef();
        logic [NR*32-1:0] snap;
        logic [31:0] r;
        snap = reg_flat;
        cs_on();
        xfer(8'h1F, 1, 32'hFF, r);
        xfer(8'h9F, 1, 32'h0, r);
        chk("R8 undefined reads zero", r, 32'h0);
        xfer(8'h83, 1, 32'h0, r);
        cs_off();
        chk("R8 one-byte phase", r, 32'h5A);
        for (int i = 0; i < NR; i++) chk("R8 no register changed", slot(i), snap[i*32 +: 32]);
    endtask

    task automatic t_ignored_bits();
        logic [31:0] r;
        cs_on(); xfer(8'h63, 1, 32'h99, r); xfer(8'hE3, 1, 32'h0, r); cs_off();
        chk("R1 bits 6:5 ignored write", slot(3), 32'h99);
        chk("R1 bits 6:5 ignored read", r, 32'h99);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_ctrl2();
        t_ftw_partial();
        t_reads();
        t_back2back();
        t_abort();
        t_cs_abort();
        t_undef();
        t_ignored_bits();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule